// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Aligner

This block takes a stream of 32-bit, word-aligned fetch words and hands a processor's fetch stage one instruction at a time. Instructions are either 16 or 32 bits long. A 32-bit instruction may start in the upper half of one word and end in the lower half of the next. The block keeps the address of the instruction it is presenting. A branch input loads that address, and each accepted instruction moves it forward by its own length. A 16-bit holding register keeps the unused upper half of a word so that such straddling instructions can be put back together.

Both sides use valid/ready. On the input side a word moves when `in_valid` and `in_ready` are both high. `in_ready` is high only when the internal storage can take a whole word, so an accepted word is never dropped except by a branch. The upstream source must deliver words in order, starting at the word that holds the branch target. On the output side an instruction moves when `out_valid` and `out_ready` are both high and `branch` is low. The core may drive `out_ready` freely. After an error is presented, the core is expected to branch before it accepts anything else.

Top module: `fetch_aligner`

## Requirements
- R1: An instruction whose bits [1:0] equal 2'b11 is 32 bits long; any other value marks a 16-bit instruction, found in `out_instr[15:0]`.
- R2: When an instruction is accepted with `branch` low, `out_addr` increases by 4 for a 32-bit instruction and by 2 for a 16-bit one, in the next cycle.
- R3: A branch sets `out_addr` to `branch_addr` in the next cycle, and the next instruction presented is the one at that address. If bit 1 of the target is set, the low half of the first word that arrives is skipped. `branch_addr[0]` must be zero.
- R4: While `out_valid` is high, `out_ready` is low, `branch` is low and `out_err` is low, the next cycle keeps `out_valid`, `out_addr`, `out_err` and `out_instr[15:0]` unchanged. For a 32-bit instruction, the upper bits stay unchanged as well.
- R5: A 32-bit instruction at an address with bit 1 set is presented as {low half of the next word, held upper half}. It is presented only once both halves have arrived, or once an error has been reported for its first half.
- R6: `out_err` is high when the word holding any part of the presented instruction arrived with `in_err` set.
- R7: `out_err_hi` is high only when `out_valid` and `out_err` are high, the instruction is 32 bits long, its first half is clean, and the word holding its second half arrived with an error.
- R8: `in_ready` is low during a branch. Otherwise it is high exactly when no full word is buffered: either the address has bit 1 clear and nothing is stored, or the address has bit 1 set and at most the upper halfword is stored.
- R9: After reset, `out_valid` is low, `in_ready` is high and `out_addr` is zero.
- R10: A branch discards the held halfword and any buffered word in the same cycle, so `out_valid` is low in the cycle after a branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| branch | input | 1 | Load the address counter and flush stored data |
| branch_addr | input | AW | Branch target, halfword aligned |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Block can take an input word |
| in_word | input | IW | Aligned fetch word |
| in_err | input | 1 | Fetch of this word failed |
| out_valid | output | 1 | Instruction presented |
| out_ready | input | 1 | Fetch stage takes the instruction |
| out_instr | output | IW | Instruction bits, 16-bit ones in the low half |
| out_addr | output | AW | Address of the presented instruction |
| out_err | output | 1 | Instruction fetch failed |
| out_err_hi | output | 1 | Failure lies in the second half of a straddling instruction |

## Verification
The bench targets straddling 32-bit instructions, both after sequential flow and right after a branch to an address with bit 1 set. A design that skipped the wrong half, or that presented the instruction before its second word arrived, would show the wrong bits or an early `out_valid`. Errors are placed so that they sometimes land only on the second word of a straddling instruction. A design that attributed them wrongly would drop `out_err`, or would raise `out_err_hi` for a clean first half or for a 16-bit instruction. Branches are issued while output back-pressure is on and words are stored, so stale data left after a flush, a counter that steps by the wrong length, or an `in_ready` that over- or under-admits words all show up against the reference queue.

// File: rtl/fa_pkg.sv
package fa_pkg;

  localparam int unsigned HALF_W = 16;

  typedef struct packed {
    logic              vld;
    logic              err;
    logic [HALF_W-1:0] bits;
  } half_t;

  function automatic logic is_wide(input logic [1:0] lo_bits);
    return lo_bits == 2'b11;
  endfunction

endpackage

// File: rtl/fa_addr_ctr.sv
module fa_addr_ctr #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] target,
  input  logic          adv,
  input  logic          step4,
  output logic [AW-1:0] addr
);

  localparam logic [AW-1:0] STEP_S = AW'(2);
  localparam logic [AW-1:0] STEP_L = AW'(4);

  logic [AW-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (load) begin
      addr_q <= {target[AW-1:1], 1'b0};
    end else if (adv) begin
      addr_q <= addr_q + (step4 ? STEP_L : STEP_S);
    end
  end

  assign addr = addr_q;

endmodule

// File: rtl/fa_word_buf.sv
module fa_word_buf #(
  parameter int unsigned IW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          load,
  input  logic          take,
  input  logic [IW-1:0] d,
  input  logic          d_err,
  output logic          vld,
  output logic [IW-1:0] q,
  output logic          q_err
);

  logic          vld_q;
  logic          err_q;
  logic [IW-1:0] dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      err_q <= 1'b0;
    end else if (flush || take) begin
      vld_q <= 1'b0;
      err_q <= 1'b0;
    end else if (load) begin
      vld_q <= 1'b1;
      err_q <= d_err;
    end
  end

  always_ff @(posedge clk) begin
    if (load && !flush) begin
      dat_q <= d;
    end
  end

  assign vld   = vld_q;
  assign q     = dat_q;
  assign q_err = err_q;

endmodule

// File: rtl/fa_half_skid.sv
module fa_half_skid
  import fa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              load,
  input  logic              clear,
  input  logic [HALF_W-1:0] d,
  input  logic              d_err,
  output half_t             slot
);

  half_t slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
    end else if (flush) begin
      slot_q.vld <= 1'b0;
      slot_q.err <= 1'b0;
    end else if (load) begin
      slot_q.vld  <= 1'b1;
      slot_q.err  <= d_err;
      slot_q.bits <= d;
    end else if (clear) begin
      slot_q.vld <= 1'b0;
      slot_q.err <= 1'b0;
    end
  end

  assign slot = slot_q;

endmodule

// File: rtl/fa_select.sv
module fa_select
  import fa_pkg::*;
#(
  parameter int unsigned IW = 32
) (
  input  logic          odd_half,
  input  logic          w_vld,
  input  logic [IW-1:0] w_q,
  input  logic          w_err,
  input  half_t         hold,
  input  logic          out_ready,
  input  logic          branch,
  output logic          out_valid,
  output logic [IW-1:0] out_instr,
  output logic          out_err,
  output logic          out_err_hi,
  output logic          adv,
  output logic          step4,
  output logic          w_take,
  output logic          h_from_w,
  output logic          h_clear
);

  logic wide_w;
  logic wide_h;
  logic fire;

  assign wide_w = is_wide(w_q[1:0]);
  assign wide_h = is_wide(hold.bits[1:0]);
  assign fire   = out_valid && out_ready && !branch;
  assign adv    = fire;

  always_comb begin
    out_valid  = 1'b0;
    out_instr  = w_q;
    out_err    = 1'b0;
    out_err_hi = 1'b0;
    step4      = 1'b0;
    w_take     = 1'b0;
    h_from_w   = 1'b0;
    h_clear    = 1'b0;
    if (!odd_half) begin
      out_valid = w_vld;
      out_instr = w_q;
      out_err   = w_err;
      step4     = wide_w;
      w_take    = fire;
      h_from_w  = fire && !wide_w;
    end else begin
      out_valid  = hold.vld && (!wide_h || hold.err || w_vld);
      out_instr  = {w_q[HALF_W-1:0], hold.bits};
      out_err    = hold.err || (wide_h && w_vld && w_err);
      out_err_hi = wide_h && !hold.err && w_vld && w_err;
      step4      = wide_h;
      w_take     = fire && wide_h && w_vld;
      h_from_w   = fire && wide_h && w_vld;
      h_clear    = fire && !(wide_h && w_vld);
    end
  end

endmodule

// File: rtl/fetch_aligner.sv
module fetch_aligner
  import fa_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned IW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          branch,
  input  logic [AW-1:0] branch_addr,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [IW-1:0] in_word,
  input  logic          in_err,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [IW-1:0] out_instr,
  output logic [AW-1:0] out_addr,
  output logic          out_err,
  output logic          out_err_hi
);

  localparam int unsigned HI_LSB = IW - HALF_W;

  logic [AW-1:0]     addr;
  logic              w_vld;
  logic [IW-1:0]     w_q;
  logic              w_err;
  half_t             hold;
  logic              adv;
  logic              step4;
  logic              w_take;
  logic              h_from_w;
  logic              h_clear;
  logic              in_fire;
  logic              skip_lo;
  logic              w_load;
  logic              h_load;
  logic [HALF_W-1:0] h_d;
  logic              h_d_err;

  assign in_ready = !branch && !w_vld;
  assign in_fire  = in_valid && in_ready;
  // bit 1 set with an empty holding slot only occurs right after a branch
  assign skip_lo  = addr[1] && !hold.vld;
  assign w_load   = in_fire && !skip_lo;
  assign h_load   = h_from_w || (in_fire && skip_lo);
  assign h_d      = h_from_w ? w_q[IW-1:HI_LSB] : in_word[IW-1:HI_LSB];
  assign h_d_err  = h_from_w ? w_err : in_err;

  fa_addr_ctr #(.AW(AW)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (branch),
    .target (branch_addr),
    .adv    (adv),
    .step4  (step4),
    .addr   (addr)
  );

  fa_word_buf #(.IW(IW)) u_word (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (branch),
    .load  (w_load),
    .take  (w_take),
    .d     (in_word),
    .d_err (in_err),
    .vld   (w_vld),
    .q     (w_q),
    .q_err (w_err)
  );

  fa_half_skid u_skid (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (branch),
    .load  (h_load),
    .clear (h_clear),
    .d     (h_d),
    .d_err (h_d_err),
    .slot  (hold)
  );

  fa_select #(.IW(IW)) u_sel (
    .odd_half   (addr[1]),
    .w_vld      (w_vld),
    .w_q        (w_q),
    .w_err      (w_err),
    .hold       (hold),
    .out_ready  (out_ready),
    .branch     (branch),
    .out_valid  (out_valid),
    .out_instr  (out_instr),
    .out_err    (out_err),
    .out_err_hi (out_err_hi),
    .adv        (adv),
    .step4      (step4),
    .w_take     (w_take),
    .h_from_w   (h_from_w),
    .h_clear    (h_clear)
  );

  assign out_addr = addr;

endmodule

// File: rtl/fetch_aligner_chk.sv
module fetch_aligner_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned IW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          branch,
  input logic [AW-1:0] branch_addr,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [IW-1:0] out_instr,
  input logic [AW-1:0] out_addr,
  input logic          out_err,
  input logic          out_err_hi
);

  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !branch && !out_err) |=>
      (out_valid && $stable(out_addr) && !out_err && $stable(out_instr[15:0]))); // R4

  AST_HI_ERR_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_err_hi |-> (out_valid && out_err && out_instr[1:0] == 2'b11)); // R7

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !branch) |=>
      (out_addr == $past(out_addr) + (($past(out_instr[1:0]) == 2'b11) ? AW'(4) : AW'(2)))); // R2

  AST_BRANCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    branch |=> (out_addr == {$past(branch_addr[AW-1:1]), 1'b0})); // R3

  AST_BRANCH_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    branch |=> !out_valid); // R10

  AST_NO_INTAKE_ON_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    branch |-> !in_ready); // R8

endmodule

bind fetch_aligner fetch_aligner_chk #(.AW(AW), .IW(IW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .branch      (branch),
  .branch_addr (branch_addr),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_instr   (out_instr),
  .out_addr    (out_addr),
  .out_err     (out_err),
  .out_err_hi  (out_err_hi)
);

// File: tb/fetch_aligner_tb.sv
module fetch_aligner_tb;

  localparam int unsigned AW = 32;
  localparam int unsigned IW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          branch;
  logic [AW-1:0] branch_addr;
  logic          in_valid;
  logic          in_ready;
  logic [IW-1:0] in_word;
  logic          in_err;
  logic          out_valid;
  logic          out_ready;
  logic [IW-1:0] out_instr;
  logic [AW-1:0] out_addr;
  logic          out_err;
  logic          out_err_hi;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  fetch_aligner #(.AW(AW), .IW(IW)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .branch      (branch),
    .branch_addr (branch_addr),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_word     (in_word),
    .in_err      (in_err),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_instr   (out_instr),
    .out_addr    (out_addr),
    .out_err     (out_err),
    .out_err_hi  (out_err_hi)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mem_half(input logic [31:0] a);
    logic [31:0] h;
    h = (a ^ 32'h5bd1e995) * 32'h9e3779b1;
    h = h ^ (h >> 15);
    return {h[19:6], (h[2:0] < 3'd3) ? {1'b0, h[5]} : 2'b11};
  endfunction

  function automatic bit mem_err(input logic [31:0] a);
    logic [31:0] h;
    h = (a >> 2) * 32'h2545f491;
    h = h ^ (h >> 13);
    return h[9:6] == 4'd5;
  endfunction

  // reference model state
  logic [15:0] qd[$];
  bit          qe[$];
  logic [31:0] m_addr;
  bit          m_skip;
  logic [31:0] up_ptr;

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit          just_br;
    bit          hold_prev;
    logic [31:0] p_addr;
    logic [15:0] p_lo;
    bit          exp_v, exp_err, wide0, br, in_fire, o_fire, exp_rdy;
    logic [31:0] tgt;

    rst_n = 1'b0; branch = 1'b0; branch_addr = '0;
    in_valid = 1'b0; in_word = '0; in_err = 1'b0; out_ready = 1'b0;
    m_addr = '0; m_skip = 1'b0; up_ptr = '0;
    just_br = 1'b0; hold_prev = 1'b0; p_addr = '0; p_lo = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R9 reset valid", {31'd0, out_valid}, 32'd0);
    chk(in_ready == 1'b1, "R9 reset ready", {31'd0, in_ready}, 32'd1);
    chk(out_addr == 32'd0, "R9 reset addr", out_addr, 32'd0);

    for (int cyc = 0; cyc < 8000; cyc++) begin
      @(negedge clk);
      wide0   = (qd.size() > 0) && (qd[0][1:0] == 2'b11);
      exp_v   = (qd.size() > 0) && (qe[0] || !wide0 || qd.size() >= 2);
      exp_err = exp_v && (qe[0] || (wide0 && qd.size() >= 2 && qe[1]));
      chk(out_valid == exp_v, "R5 valid", {31'd0, out_valid}, {31'd0, exp_v});
      if (just_br) chk(out_valid == 1'b0, "R10 flush", {31'd0, out_valid}, 32'd0);
      chk(out_addr == m_addr, just_br ? "R3 target" : "R2 addr", out_addr, m_addr);
      if (hold_prev)
        chk(out_valid && out_addr == p_addr && out_instr[15:0] == p_lo, "R4 stable",
            {out_addr[15:0], out_instr[15:0]}, {p_addr[15:0], p_lo});
      if (exp_v && out_valid) begin
        chk(out_err == exp_err, "R6 err", {31'd0, out_err}, {31'd0, exp_err});
        if (exp_err) begin
          chk(out_err_hi == (wide0 && !qe[0] && qe[1]), "R7 err_hi",
              {31'd0, out_err_hi}, {31'd0, (wide0 && !qe[0] && qe[1])});
        end else begin
          chk(out_err_hi == 1'b0, "R7 clean", {31'd0, out_err_hi}, 32'd0);
          chk(out_instr[15:0] == qd[0], "R1 low half", {16'd0, out_instr[15:0]}, {16'd0, qd[0]});
          if (wide0)
            chk(out_instr[31:16] == qd[1], "R5 upper half", {16'd0, out_instr[31:16]}, {16'd0, qd[1]});
        end
      end

      br  = (cyc == 0) || ($urandom % 20 == 0) || (out_valid && out_err);
      tgt = 32'h100 + (($urandom % 64) << 1);
      branch      = br;
      branch_addr = tgt;
      out_ready   = ($urandom % 4) != 0;
      in_valid    = ($urandom % 3) != 0;
      in_word     = {mem_half(up_ptr + 2), mem_half(up_ptr)};
      in_err      = mem_err(up_ptr);
      #1;
      exp_rdy = !br && (m_addr[1] ? (qd.size() <= 1) : (qd.size() == 0));
      chk(in_ready == exp_rdy, "R8 ready", {31'd0, in_ready}, {31'd0, exp_rdy});
      in_fire   = in_valid && in_ready;
      o_fire    = out_valid && out_ready && !br;
      hold_prev = out_valid && !out_ready && !br && !out_err;
      p_addr    = out_addr;
      p_lo      = out_instr[15:0];

      if (br) begin
        qd.delete(); qe.delete();
        m_addr = tgt; m_skip = tgt[1]; up_ptr = tgt & ~32'd3;
      end else begin
        if (o_fire && qd.size() > 0) begin
          if (wide0) begin
            void'(qd.pop_front()); void'(qe.pop_front());
            void'(qd.pop_front()); void'(qe.pop_front());
            m_addr = m_addr + 4;
          end else begin
            void'(qd.pop_front()); void'(qe.pop_front());
            m_addr = m_addr + 2;
          end
        end
        if (in_fire) begin
          if (!m_skip) begin
            qd.push_back(in_word[15:0]); qe.push_back(in_err);
          end
          qd.push_back(in_word[31:16]); qe.push_back(in_err);
          m_skip = 1'b0;
          up_ptr = up_ptr + 4;
        end
      end
      just_br = br;
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule